// File: doc/BRIEF.md
# Dual-Channel Converter Configuration Register Bank

This block is the byte-wide configuration store of a two-channel data converter. A serial front end, which is not part of this block, presents each access as an 8-bit address with a write strobe, write data or a read strobe. Writes go into a set of staging (master) registers. Writing a 1 to the commit bit copies every staged value into the live (slave) registers that drive the control outputs. The live controls are power mode, external-pin meaning, test pattern and the two pattern-generator resets for each channel, plus a shared clock-divide code and a duty-cycle stabiliser enable.

A channel-select register chooses which channel copies a per-channel write updates. Global registers ignore it. A read of a per-channel register returns the staged copy of the lowest-numbered selected channel. The port-setup byte stores its bit-order and self-clear reset flags twice, in mirrored positions, so the byte decodes the same way whichever shift order the front end uses.

Top module: `conv_cfg_bank`

## Requirements
- R1: After reset the register reads are: port setup (0x00) = 0x18, channel select (0x05) = 0x03, clock control (0x09) = 0x01, and every other register = 0x00. The outputs are: all power modes 00, pin_stby 0, test patterns 0, PN resets 0, clk_div 0 and dcs_en 1.
- R2: The only decoded addresses are 0x00, 0x01, 0x02, 0x05, 0x08, 0x09, 0x0B, 0x0D and 0xFF. Every other address reads 0x00, and a write to it changes no register and no output.
- R3: The bit-order flag sits in both bit 6 and bit 1 of 0x00, and a write sets it if either bit is 1. The byte reads back as 0x18 with both bits equal to the flag, so 0x5A when the flag is set.
- R4: Address 0x01 always reads the identifier 0x32, and writes to it are ignored.
- R5: Address 0x02 always reads the parameter GRADE in bits 5:4, with all other bits 0. Writes to it are ignored.
- R6: Bit c of 0x05 enables channel c (bit 0 = channel A, bit 1 = channel B). A write to 0x08 or 0x0D updates only the enabled channels. A read of 0x08 or 0x0D returns the lowest enabled channel's staged value, or 0x00 when no channel is enabled.
- R7: Writes update only the staged copy, which reads return at once. The outputs do not change until a commit.
- R8: A write to 0xFF with bit 0 = 1 copies all staged values to the outputs, which show them one clock after the write edge. 0xFF always reads 0x00, and a write with bit 0 = 0 has no effect.
- R9: In 0x08, bits 1:0 hold the power mode (00/11 normal, 01 power-down, 10 standby) and drive pwr_mode[2c+1:2c]. Bit 5 is the pin meaning and drives pin_stby[c]. The other bits read 0.
- R10: In 0x0B, bits 2:0 hold the divide code (code N divides by N+1) and drive clk_div. In 0x09, bit 0 is the stabiliser enable. dcs_en is 1 whenever the live divide code is nonzero, whatever 0x09 holds.
- R11: In 0x0D, bits 2:0 are the pattern and drive test_pat[3c+2:3c]. Bit 4 drives pn_short_rst[c] and bit 5 drives pn_long_rst[c]. The other bits read 0.
- R12: A write to 0x00 with bit 5 or bit 2 set returns every staged and live register to its R1 value on that edge. The reset bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; rdata is loaded on the same edge |
| rdata | output | 8 | Read data, held until the next read |
| pwr_mode | output | 2*NCH | Live power mode per channel |
| pin_stby | output | NCH | Live external-pin meaning per channel (1 = standby) |
| test_pat | output | 3*NCH | Live test pattern code per channel |
| pn_short_rst | output | NCH | Live short PN generator reset per channel |
| pn_long_rst | output | NCH | Live long PN generator reset per channel |
| clk_div | output | 3 | Live clock divide code |
| dcs_en | output | 1 | Duty-cycle stabiliser active |

## Verification
The bench builds the block with NCH = 2 and GRADE = 2'b10, so the grade byte must read 0x20 rather than the default 0x10. This exposes a hard-wired grade value. Two channels allow all four channel-select values: both channels, A only, B only and none. That in turn exercises the lowest-enabled read rule and the writes that no channel accepts.

// File: rtl/conv_cfg_bank.sv
module conv_cfg_bank #(
  parameter int         NCH     = 2,
  parameter logic [1:0] GRADE   = 2'b01,
  parameter logic [7:0] CHIP_ID = 8'h32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic [7:0]       rdata,
  output logic [2*NCH-1:0] pwr_mode,
  output logic [NCH-1:0]   pin_stby,
  output logic [3*NCH-1:0] test_pat,
  output logic [NCH-1:0]   pn_short_rst,
  output logic [NCH-1:0]   pn_long_rst,
  output logic [2:0]       clk_div,
  output logic             dcs_en
);
  localparam logic [NCH-1:0] SEL_ALL = '1;

  logic           lsb_first;
  logic [NCH-1:0] ch_sel;
  logic           dcs_m, dcs_s;
  logic [2:0]     div_m, div_s;
  logic [3*NCH-1:0] pwr_m_all;
  logic [5*NCH-1:0] tst_m_all;
  logic [7:0]     rval;

  wire srst = wr_en && addr == 8'h00 && (wdata[5] || wdata[2]);
  wire xfer = wr_en && addr == 8'hFF && wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lsb_first <= 1'b0; ch_sel <= SEL_ALL;
      dcs_m <= 1'b1; dcs_s <= 1'b1; div_m <= '0; div_s <= '0;
    end else if (srst) begin
      lsb_first <= 1'b0; ch_sel <= SEL_ALL;
      dcs_m <= 1'b1; dcs_s <= 1'b1; div_m <= '0; div_s <= '0;
    end else begin
      if (wr_en && addr == 8'h00) lsb_first <= wdata[6] | wdata[1];
      if (wr_en && addr == 8'h05) ch_sel <= wdata[NCH-1:0];
      if (wr_en && addr == 8'h09) dcs_m <= wdata[0];
      if (wr_en && addr == 8'h0B) div_m <= wdata[2:0];
      if (xfer) begin dcs_s <= dcs_m; div_s <= div_m; end
    end

  assign clk_div = div_s;
  assign dcs_en  = dcs_s | (div_s != 3'd0);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [2:0] pwr_m, pwr_s;
    logic [4:0] tst_m, tst_s;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pwr_m <= '0; pwr_s <= '0; tst_m <= '0; tst_s <= '0;
      end else if (srst) begin
        pwr_m <= '0; pwr_s <= '0; tst_m <= '0; tst_s <= '0;
      end else begin
        if (wr_en && addr == 8'h08 && ch_sel[c]) pwr_m <= {wdata[5], wdata[1:0]};
        if (wr_en && addr == 8'h0D && ch_sel[c]) tst_m <= {wdata[5:4], wdata[2:0]};
        if (xfer) begin pwr_s <= pwr_m; tst_s <= tst_m; end
      end
    assign pwr_m_all[3*c +: 3] = pwr_m;
    assign tst_m_all[5*c +: 5] = tst_m;
    assign pwr_mode[2*c +: 2]  = pwr_s[1:0];
    assign pin_stby[c]         = pwr_s[2];
    assign test_pat[3*c +: 3]  = tst_s[2:0];
    assign pn_short_rst[c]     = tst_s[3];
    assign pn_long_rst[c]      = tst_s[4];
  end

  always_comb begin
    logic       found;
    logic [2:0] pw;
    logic [4:0] ts;
    found = 1'b0; pw = '0; ts = '0;
    for (int c = 0; c < NCH; c++)
      if (ch_sel[c] && !found) begin
        found = 1'b1;
        pw = pwr_m_all[3*c +: 3];
        ts = tst_m_all[5*c +: 5];
      end
    case (addr)
      8'h00:   rval = {1'b0, lsb_first, 3'b011, 1'b0, lsb_first, 1'b0};
      8'h01:   rval = CHIP_ID;
      8'h02:   rval = {2'b00, GRADE, 4'b0000};
      8'h05:   rval = {{(8-NCH){1'b0}}, ch_sel};
      8'h08:   rval = {2'b00, pw[2], 3'b000, pw[1:0]};
      8'h09:   rval = {7'd0, dcs_m};
      8'h0B:   rval = {5'd0, div_m};
      8'h0D:   rval = {2'b00, ts[4:3], 1'b0, ts[2:0]};
      default: rval = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_en) rdata <= rval;

  // R4
  a_r4_fixed_id: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 8'h01 |=> rdata == CHIP_ID);

  // R2
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !(addr inside {8'h00, 8'h01, 8'h02, 8'h05, 8'h08, 8'h09, 8'h0B, 8'h0D}) |=> rdata == 8'h00);

  // R7 / R8: live outputs move only after a commit or a soft reset
  a_r8_hold_until_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == 8'hFF || addr == 8'h00)) |=>
      $stable(pwr_mode) && $stable(pin_stby) && $stable(test_pat) && $stable(pn_short_rst)
      && $stable(pn_long_rst) && $stable(clk_div) && $stable(dcs_en));

  // R12
  a_r12_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> dcs_en && clk_div == 3'd0 && pwr_mode == '0 && test_pat == '0
             && pin_stby == '0 && pn_short_rst == '0 && pn_long_rst == '0);

  // R10
  a_r10_div_forces_dcs: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && div_m != 3'd0 |=> dcs_en);
endmodule

// File: tb/conv_cfg_bank_test.sv
module conv_cfg_bank_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rdata;
  logic [3:0] pwr_mode;
  logic [1:0] pin_stby, pn_short_rst, pn_long_rst;
  logic [5:0] test_pat;
  logic [2:0] clk_div;
  logic dcs_en;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  conv_cfg_bank #(.NCH(2), .GRADE(2'b10)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .pwr_mode(pwr_mode), .pin_stby(pin_stby), .test_pat(test_pat),
    .pn_short_rst(pn_short_rst), .pn_long_rst(pn_long_rst), .clk_div(clk_div), .dcs_en(dcs_en));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    chk("R1 dcs_en", dcs_en, 1); chk("R1 pwr_mode", pwr_mode, 0);
    chk("R1 clk_div", clk_div, 0); chk("R1 test_pat", test_pat, 0);
    rchk("R1 reg00", 8'h00, 8'h18); rchk("R1 reg05", 8'h05, 8'h03);
    rchk("R1 reg09", 8'h09, 8'h01); rchk("R1 reg08", 8'h08, 8'h00);
  endtask

  task automatic t_unmapped;
    wr(8'h07, 8'hAA); rchk("R2 reg07", 8'h07, 8'h00);
    rchk("R2 reg03", 8'h03, 8'h00);
    wr(8'h01, 8'h00); rchk("R4 id", 8'h01, 8'h32);
    wr(8'h02, 8'hFF); rchk("R5 grade", 8'h02, 8'h20);
    wr(8'hFF, 8'h01); chk("R2 outputs untouched", {pwr_mode, test_pat, clk_div, dcs_en}, 14'h0001);
  endtask

  task automatic t_mirror;
    wr(8'h00, 8'h40); rchk("R3 bit6", 8'h00, 8'h5A);
    wr(8'h00, 8'h00); rchk("R3 clear", 8'h00, 8'h18);
    wr(8'h00, 8'h02); rchk("R3 bit1", 8'h00, 8'h5A);
  endtask

  task automatic t_shadow_index;
    wr(8'h08, 8'h21); rchk("R7 staged read", 8'h08, 8'h21);
    chk("R7 not live", pwr_mode, 0);
    wr(8'hFF, 8'h00); chk("R8 zero commit", pwr_mode, 0);
    wr(8'hFF, 8'h01); chk("R9 pwr_mode", pwr_mode, 4'b0101);
    chk("R9 pin_stby", pin_stby, 2'b11);
    rchk("R8 reg FF", 8'hFF, 8'h00);
    wr(8'h05, 8'h01); wr(8'h08, 8'h02); wr(8'hFF, 8'h01);
    chk("R6 A only", pwr_mode, 4'b0110); chk("R6 A pin", pin_stby, 2'b10);
    wr(8'h05, 8'h02); rchk("R6 read B", 8'h08, 8'h21);
    wr(8'h05, 8'h00); rchk("R6 none", 8'h08, 8'h00);
    wr(8'h08, 8'h03); wr(8'h05, 8'h03); rchk("R6 ignored", 8'h08, 8'h02);
    wr(8'h08, 8'hFF); rchk("R9 masked bits", 8'h08, 8'h23);
  endtask

  task automatic t_test;
    wr(8'h0D, 8'h35); rchk("R11 read", 8'h0D, 8'h35);
    wr(8'hFF, 8'h01);
    chk("R11 pattern", test_pat, 6'b101101);
    chk("R11 short", pn_short_rst, 2'b11); chk("R11 long", pn_long_rst, 2'b11);
    wr(8'h0D, 8'hFF); rchk("R11 masked", 8'h0D, 8'h37);
  endtask

  task automatic t_clock;
    wr(8'h09, 8'h00); wr(8'hFF, 8'h01); chk("R10 dcs off", dcs_en, 0);
    wr(8'h0B, 8'h04); chk("R7 div staged", clk_div, 0); chk("R10 dcs staged", dcs_en, 0);
    wr(8'hFF, 8'h01); chk("R10 div live", clk_div, 4); chk("R10 forced", dcs_en, 1);
    rchk("R10 reg09", 8'h09, 8'h00); rchk("R10 reg0B", 8'h0B, 8'h04);
  endtask

  task automatic t_srst(input logic [7:0] v);
    wr(8'h05, 8'h01); wr(8'h08, 8'h01); wr(8'hFF, 8'h01);
    wr(8'h00, v);
    chk("R12 outputs", {pwr_mode, pin_stby, test_pat, clk_div, dcs_en}, 16'h0001);
    rchk("R12 reg00", 8'h00, 8'h18); rchk("R12 reg05", 8'h05, 8'h03);
    rchk("R12 reg08", 8'h08, 8'h00); rchk("R12 reg09", 8'h09, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_unmapped; t_mirror; t_shadow_index; t_test; t_clock;
    t_srst(8'h20); t_srst(8'h04);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule